// File: doc/BRIEF.md
# Programmable Duty Pulse Tone Channel

This block is a square-wave tone source driven by the system clock. A 12-bit period field N sets a prescale of N+1 clocks. Each prescale window moves a 16-position duty sequencer one step forward, so a full waveform lasts 16*(N+1) clocks. A 3-bit duty code picks how many of the 16 positions drive the waveform high. While the waveform bit is high, the 4-bit volume word reaches the channel output. While it is low, the output is zero.

Two control bits change this behaviour. With the gate bit set, the waveform bit is held high, so the volume field appears directly on the output as a raw 4-bit sample. Clearing the enable bit forces the waveform low, and enable wins over gate. While the channel is disabled, the prescaler and the sequencer stay at zero. Each time the channel is enabled, the waveform therefore starts from its first high step. A surrounding design feeds the fields from its own register decode and sums the output with other channels.

Top module: `pulse_tone_chan`

## Requirements
- R1: With period field N (0 to 4095), the sequencer advances exactly once every N+1 clock cycles while enabled.
- R2: The sequencer has 16 steps and wraps, so the waveform repeats every 16*(N+1) cycles, and step 0 follows step 15.
- R3: With duty code D, the waveform is high for steps 0 through D, which is (D+1)*(N+1) cycles at the start of each repetition. D=0 gives 1/16 and D=7 gives 8/16.
- R4: The output equals the volume word while the waveform is high and equals 0 while it is low. Volume 0 gives a silent output.
- R5: With the gate bit at 1 and the channel enabled, the output equals the volume word on every cycle, and follows a volume change in the same cycle.
- R6: With the enable bit at 0, the output is 0, even when the gate bit is 1.
- R7: While disabled, the prescaler and the step are held at zero. After enable rises, step 0 begins in the first enabled cycle and lasts a full N+1 cycles.
- R8: A change to the period field does not shorten or stretch the step in progress. The new period applies from the next step boundary.
- R9: A synchronous active-low reset clears the prescaler and the step. After release with the channel enabled, step 0 lasts N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_i | input | 3 | Duty code D, high for D+1 of 16 steps |
| vol_i | input | 4 | Volume word, or the raw sample when gated |
| gate_i | input | 1 | 1 holds the waveform bit high |
| en_i | input | 1 | 1 runs the channel, 0 silences and clears it |
| period_i | input | 12 | Prescale value N, step length N+1 cycles |
| level_o | output | 4 | Channel output level |

## Verification
The output is a combinational function of the registered step and the present inputs. A change to gate, enable, volume or duty therefore shows at the output in the same cycle, and the step only moves at the clock edge that closes each N+1-cycle window. The bench changes inputs on the falling edge and samples 1 ns later. It numbers the samples by the rising edges counted since enable, or since reset release. This makes the expected level at sample i a function only of i/(N+1) modulo 16 and the duty code. For period changes, the expected boundary sits N_old+1 samples after enable.

// File: rtl/pulse_tone_pkg.sv
// Package: default field widths shared by the pulse tone channel modules.
// Assumes the step counter is one bit wider than the duty code, so that
// a duty code selects up to half of the sequencer steps.
package pulse_tone_pkg;
    parameter int unsigned PT_PER_W  = 12;
    parameter int unsigned PT_DUTY_W = 3;
    parameter int unsigned PT_VOL_W  = 4;
endpackage

// File: rtl/pt_divider.sv
// Module: pt_divider
// Prescaler that emits one tick every (limit+1) enabled cycles. It counts
// up from zero to a limit that is captured from period_i at each wrap, so
// a period change applies only from the next step boundary.
// Assumes: en_i low or reset clears the count and loads the limit.
module pt_divider #(
    parameter int unsigned PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o
);
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] lim_q;
    logic             wrap;

    // Purpose: flag the last cycle of the current prescale window.
    always_comb begin
        wrap   = (cnt_q == lim_q);
        tick_o = en_i && wrap;
    end

    // Purpose: advance the count, wrap at the limit and capture a new limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
            lim_q <= period_i;
        end else if (wrap) begin
            cnt_q <= '0;
            lim_q <= period_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q <= lim_q)); // R1
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0)); // R7
    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !wrap) |=> $stable(lim_q)); // R8
endmodule

// File: rtl/pt_step_seq.sv
// Module: pt_step_seq
// Duty sequencer: a wrapping step counter that moves forward on each
// prescaler tick. Assumes tick_i is only high while en_i is high.
module pt_step_seq #(
    parameter int unsigned STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    output logic [STEP_W-1:0] step_o
);
    logic [STEP_W-1:0] step_q;

    // Purpose: hold at zero while off, otherwise step once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            step_q <= '0;
        end else if (tick_i) begin
            step_q <= step_q + 1'b1;
        end
    end

    assign step_o = step_q;

    AST_STEP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(step_q)); // R1
    AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (step_q == $past(step_q) + 1'b1)); // R2
    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |-> en_i); // R7
endmodule

// File: rtl/pt_level_gate.sv
// Module: pt_level_gate
// Forms the waveform bit from step and duty, applies the gate and enable
// overrides, and puts the volume word on the output while the bit is high.
// Assumes STEP_W >= DUTY_W. The clock and reset only time the assertions.
module pt_level_gate #(
    parameter int unsigned STEP_W = 4,
    parameter int unsigned DUTY_W = 3,
    parameter int unsigned VOL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [VOL_W-1:0]  vol_i,
    input  logic              gate_i,
    input  logic              en_i,
    output logic [VOL_W-1:0]  level_o
);
    logic wave;

    // Purpose: waveform bit, where enable outranks gate and gate outranks duty.
    always_comb begin
        wave    = en_i && (gate_i || (step_i <= STEP_W'(duty_i)));
        level_o = wave ? vol_i : '0;
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (level_o == '0)); // R6
    AST_GATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && gate_i) |-> (level_o == vol_i)); // R5
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) || (level_o == vol_i)); // R4
endmodule

// File: rtl/pulse_tone_chan.sv
// Module: pulse_tone_chan
// Top of the pulse tone channel: prescaler -> duty sequencer -> level gate.
// Assumes the register fields are held stable by the surrounding decode
// and that rst_n is synchronous to clk.
module pulse_tone_chan
    import pulse_tone_pkg::*;
#(
    parameter int unsigned PER_W  = PT_PER_W,
    parameter int unsigned DUTY_W = PT_DUTY_W,
    parameter int unsigned VOL_W  = PT_VOL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [VOL_W-1:0]  vol_i,
    input  logic              gate_i,
    input  logic              en_i,
    input  logic [PER_W-1:0]  period_i,
    output logic [VOL_W-1:0]  level_o
);
    localparam int unsigned STEP_W = DUTY_W + 1;

    logic              tick;
    logic [STEP_W-1:0] step;

    pt_divider #(.PER_W(PER_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .period_i (period_i),
        .tick_o   (tick)
    );

    pt_step_seq #(.STEP_W(STEP_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .tick_i (tick),
        .step_o (step)
    );

    pt_level_gate #(.STEP_W(STEP_W), .DUTY_W(DUTY_W), .VOL_W(VOL_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .duty_i  (duty_i),
        .vol_i   (vol_i),
        .gate_i  (gate_i),
        .en_i    (en_i),
        .level_o (level_o)
    );
endmodule

// File: tb/sim_pulse_tone_chan.sv
module sim_pulse_tone_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  duty = '0;
    logic [3:0]  vol = '0;
    logic        gate = 1'b0;
    logic        en = 1'b0;
    logic [11:0] period = '0;
    logic [3:0]  level;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pulse_tone_chan u0 (
        .clk(clk), .rst_n(rst_n), .duty_i(duty), .vol_i(vol),
        .gate_i(gate), .en_i(en), .period_i(period), .level_o(level)
    );

    // Vector fields: period[18:7], duty[6:4], volume[3:0]
    localparam int NV = 6;
    localparam logic [18:0] VEC [NV] = '{
        {12'd0,  3'd0, 4'd15},
        {12'd0,  3'd7, 4'd9},
        {12'd2,  3'd3, 4'd5},
        {12'd5,  3'd6, 4'd1},
        {12'd1,  3'd2, 4'd0},
        {12'd12, 3'd1, 4'd10}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Enable from a cleared state and compare one full repetition plus the wrap sample.
    task automatic run_wave(input int n, input int d, input int v, input bit tail_only);
        int len = 16 * (n + 1);
        int miss = 0;
        int first_bad = -1;
        int got = 0;
        int want = 0;
        @(negedge clk);
        en = 1'b0; gate = 1'b0;
        period = 12'(n); duty = 3'(d); vol = 4'(v);
        @(negedge clk);
        #1;
        chk(level == 4'd0, "R6 disabled output", int'(level), 0);
        @(negedge clk);
        en = 1'b1;
        for (int i = 0; i <= len; i++) begin
            #1;
            if (!tail_only || i == (d + 1) * (n + 1) - 1 || i == (d + 1) * (n + 1) || i == len) begin
                want = (i == len) ? v : (((i / (n + 1)) <= d) ? v : 0);
                if (int'(level) != want) begin
                    miss++;
                    if (first_bad < 0) begin
                        first_bad = i; got = int'(level);
                    end
                end
            end
            @(negedge clk);
        end
        if (miss != 0)
            $display("  first mismatch at cycle %0d (N=%0d D=%0d V=%0d)", first_bad, n, d, v);
        chk(miss == 0, "R1 R2 R3 R4 R7 waveform", got, want);
        repeat (3) @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int miss;
        int want;
        int st;
        // R9 reset state: disabled and in reset, output silent.
        repeat (3) @(negedge clk);
        #1;
        chk(level == 4'd0, "R9 reset output", int'(level), 0);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R4 R7.
        for (int k = 0; k < NV; k++)
            run_wave(int'(VEC[k][18:7]), int'(VEC[k][6:4]), int'(VEC[k][3:0]), 1'b0);

        // R1 upper boundary: N=4095, D=0, checked at the step edges.
        run_wave(4095, 0, 7, 1'b1);

        // R5 gate passes volume on every cycle, R6 enable outranks gate.
        @(negedge clk);
        period = 12'd5; duty = 3'd0; vol = 4'd11; gate = 1'b1; en = 1'b1;
        miss = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (level != 4'd11) miss++;
            @(negedge clk);
        end
        chk(miss == 0, "R5 gated sample held", miss, 0);
        vol = 4'd3;
        #1;
        chk(level == 4'd3, "R5 gated volume same cycle", int'(level), 3);
        @(negedge clk);
        en = 1'b0;
        #1;
        chk(level == 4'd0, "R6 enable outranks gate", int'(level), 0);
        @(negedge clk);
        #1;
        chk(level == 4'd0, "R6 disabled gated stays off", int'(level), 0);
        gate = 1'b0;

        // R8 period change mid-step: old step length 4, then 1-cycle steps.
        @(negedge clk);
        period = 12'd3; duty = 3'd7; vol = 4'd12;
        repeat (2) @(negedge clk);
        en = 1'b1;
        miss = 0;
        for (int i = 0; i < 20; i++) begin
            #1;
            st = (i < 4) ? 0 : ((i - 3) % 16);
            want = (st <= 7) ? 12 : 0;
            if (int'(level) != want) miss++;
            if (i == 1) period = 12'd0;
            @(negedge clk);
        end
        chk(miss == 0, "R8 period applies at boundary", miss, 0);

        // R9 reset mid-run: step 0 lasts N+1 cycles after release.
        en = 1'b0;
        @(negedge clk);
        period = 12'd3; duty = 3'd0; vol = 4'd5; en = 1'b1;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i <= 4; i++) begin
            #1;
            want = (i <= 3) ? 5 : 0;
            chk(int'(level) == want, "R9 restart after reset", int'(level), want);
            @(negedge clk);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule